// File: doc/BRIEF.md
# Power-up Strap Latch and Clock Mode Decoder

This block reads three frequency-select straps a fixed number of reference cycles after reset is released, holds them for the rest of the session, and turns them into an operating mode for a multi-output clock generator. The most significant strap shares its pin with the reference clock output. While the strap is being read, the block leaves that pin undriven. Once the value is held, the block drives the reference clock onto the pin.

The held code picks one of three kinds of mode. The first is a board-test mode in which every output floats. The second is a bypass test mode in which each output group is a fixed division of the clock driven into the crystal input, each at 50% duty. The third kind is four normal modes. In a normal mode the block reports the processor and memory frequency select codes and the phase inversion flags for the synthesizer that follows. If the strap pins are left open, the internal pulls make them read 011, which selects 100 MHz processor and 100 MHz memory clocks. The held value also starts at 011.

Top module: `strap_mode_ctrl`

## Requirements
- R1: The straps {strap_pin_in, sel_lo[1], sel_lo[0]} are captured at rising clock edge number CAPTURE_DLY after the first edge that sees rst low. Before that edge `straps_valid` is 0, and from that edge on it is 1 until the next reset. The value captured is the one present just before that edge.
- R2: After capture, changes on `strap_pin_in` and `sel_lo` have no effect on `straps_o` or on any decoded output.
- R3: `pin_oe` is 0 until capture. After capture it is 1, except in the float mode, where it stays 0.
- R4: While `pin_oe` is 1, `pin_out` follows the reference clock: it is high in the high phase and low in the low phase. While `pin_oe` is 0, `pin_out` is low.
- R5: A captured code with bits [1:0] = 00 gives `outs_hiz`=1 and `test_mode`=0, whatever bit 2 is. `cpu_freq` reads 3, `sdram_freq` and all inversion flags read 0, and all group clocks are low.
- R6: A captured code with bits [1:0] = 01 gives `test_mode`=1 and `cpu_freq`=3. The group clocks run from the reference clock at 50% duty: grp_clk[0] (processor), grp_clk[1] (memory) and grp_clk[5] (48 MHz group) divide by 2, grp_clk[2] (66 MHz group) divides by 3, and grp_clk[3] (PCI) and grp_clk[4] (APIC) divide by 6.
- R7: `cpu_freq` is encoded 0=66, 1=100, 2=133 and 3=none, and `sdram_freq` is 0=100 and 1=133. Code 010 gives 0/0, 011 gives 1/0, 110 gives 2/1 and 111 gives 2/0.
- R8: Code 010 sets `inv_cpu` and `inv_mid`. Codes 011 and 111 set `inv_cpu` and `inv_sdram`. Every other code clears all three flags.
- R9: Outside test mode, including before capture, every bit of `grp_clk` is low.
- R10: Until capture, `straps_o` reads the open-pin default 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (crystal or driven test clock) |
| rst | input | 1 | Synchronous active-high reset |
| strap_pin_in | input | 1 | Level read from the shared strap/reference pin (strap bit 2) |
| sel_lo | input | 2 | Dedicated straps, bit 1 and bit 0 |
| straps_valid | output | 1 | Straps have been captured |
| straps_o | output | 3 | Captured strap code |
| pin_oe | output | 1 | Drive enable for the shared pin |
| pin_out | output | 1 | Reference clock driven onto the shared pin |
| outs_hiz | output | 1 | All clock outputs float |
| test_mode | output | 1 | Bypass test mode is active |
| cpu_freq | output | 2 | Processor frequency select code |
| sdram_freq | output | 1 | Memory frequency select code |
| inv_cpu | output | 1 | Invert processor clocks |
| inv_sdram | output | 1 | Invert memory clocks |
| inv_mid | output | 1 | Invert 66 MHz group clocks |
| grp_clk | output | 6 | Test-mode divided clocks per output group |

## Verification
Strap capture and the handover of the shared pin to the output driver can happen on the same edge. So can a capture and a change of the strap inputs. The bench puts one code on the pins during the cycle before capture edge CAPTURE_DLY and a different code just after that edge. It then judges the outcome by the held code, by the drive enable that rises on the same edge, and by the decoded outputs, which must all follow the first code. A sweep over all eight codes checks each mode's decode, pin handling and group clock edge and duty counts.

// File: rtl/strap_mode_pkg.sv
`timescale 1ns/1ps
package strap_mode_pkg;

    localparam int NUM_GRP   = 6;
    localparam int GRP_CPU   = 0;
    localparam int GRP_SDRAM = 1;
    localparam int GRP_MID   = 2;
    localparam int GRP_PCI   = 3;
    localparam int GRP_APIC  = 4;
    localparam int GRP_USB   = 5;

    localparam logic [2:0] STRAP_OPEN = 3'b011;

    typedef enum logic [1:0] {
        CPU_66  = 2'd0,
        CPU_100 = 2'd1,
        CPU_133 = 2'd2,
        CPU_OFF = 2'd3
    } cpu_freq_e;

    typedef struct packed {
        logic      hiz;
        logic      test;
        cpu_freq_e cpu;
        logic      sdram_133;
        logic      inv_cpu;
        logic      inv_sdram;
        logic      inv_mid;
    } mode_cfg_t;

    // Test-mode division ratio for each output group
    function automatic int grp_div(input int g);
        case (g)
            GRP_MID:           return 3;
            GRP_PCI, GRP_APIC: return 6;
            default:           return 2;
        endcase
    endfunction

    function automatic mode_cfg_t decode_straps(input logic [2:0] s);
        mode_cfg_t c;
        c     = '0;
        c.cpu = CPU_OFF;
        case (s[1:0])
            2'b00: c.hiz  = 1'b1;
            2'b01: c.test = 1'b1;
            2'b10: begin
                if (!s[2]) begin
                    c.cpu     = CPU_66;
                    c.inv_cpu = 1'b1;
                    c.inv_mid = 1'b1;
                end else begin
                    c.cpu       = CPU_133;
                    c.sdram_133 = 1'b1;
                end
            end
            default: begin
                c.cpu       = s[2] ? CPU_133 : CPU_100;
                c.inv_cpu   = 1'b1;
                c.inv_sdram = 1'b1;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
module strap_capture
    import strap_mode_pkg::*;
#(
    parameter int DLY_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] strap_in,
    output logic       valid,
    output logic [2:0] straps
);
    localparam int CW = $clog2(DLY_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            valid  <= 1'b0;
            straps <= STRAP_OPEN;
        end else if (!valid) begin
            if (cnt == CW'(DLY_CYC - 1)) begin
                valid  <= 1'b1;
                straps <= strap_in;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mode_decode.sv
`timescale 1ns/1ps
module mode_decode
    import strap_mode_pkg::*;
(
    input  logic [2:0] straps,
    output mode_cfg_t  cfg
);
    always_comb cfg = decode_straps(straps);
endmodule

// File: rtl/test_divider.sv
`timescale 1ns/1ps
module test_divider #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic clk_out
);
    generate
        if (DIV % 2 == 0) begin : g_even
            localparam int HALF = DIV / 2;
            localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
            logic [CW-1:0] cnt;
            logic          q;
            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    cnt <= '0;
                    q   <= 1'b0;
                end else if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                    q   <= ~q;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign clk_out = q;
        end else begin : g_odd
            localparam int CW = $clog2(DIV);
            localparam int HI = (DIV - 1) / 2;
            logic [CW-1:0] cnt;
            logic          p;
            logic          n;
            always_ff @(posedge clk) begin
                if (rst || !en)                 cnt <= '0;
                else if (cnt == CW'(DIV - 1))   cnt <= '0;
                else                            cnt <= cnt + 1'b1;
            end
            assign p = en && (cnt < CW'(HI));
            // half-cycle delayed copy stretches the high phase by half a period
            always_ff @(negedge clk) begin
                if (rst || !en) n <= 1'b0;
                else            n <= p;
            end
            assign clk_out = p | n;
        end
    endgenerate
endmodule

// File: rtl/strap_mode_ctrl.sv
`timescale 1ns/1ps
module strap_mode_ctrl
    import strap_mode_pkg::*;
#(
    parameter int CAPTURE_DLY = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_pin_in,
    input  logic [1:0] sel_lo,
    output logic       straps_valid,
    output logic [2:0] straps_o,
    output logic       pin_oe,
    output logic       pin_out,
    output logic       outs_hiz,
    output logic       test_mode,
    output logic [1:0] cpu_freq,
    output logic       sdram_freq,
    output logic       inv_cpu,
    output logic       inv_sdram,
    output logic       inv_mid,
    output logic [5:0] grp_clk
);
    logic [2:0] strap_in;
    mode_cfg_t  cfg;
    logic       div_en;
    logic       ref_gate;

    assign strap_in = {strap_pin_in, sel_lo};

    strap_capture #(.DLY_CYC(CAPTURE_DLY)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .strap_in (strap_in),
        .valid    (straps_valid),
        .straps   (straps_o)
    );

    mode_decode u_dec (
        .straps (straps_o),
        .cfg    (cfg)
    );

    assign outs_hiz   = cfg.hiz;
    assign test_mode  = cfg.test;
    assign cpu_freq   = cfg.cpu;
    assign sdram_freq = cfg.sdram_133;
    assign inv_cpu    = cfg.inv_cpu;
    assign inv_sdram  = cfg.inv_sdram;
    assign inv_mid    = cfg.inv_mid;

    assign div_en = straps_valid && cfg.test;

    genvar g;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : g_grp
            test_divider #(.DIV(grp_div(g))) u_div (
                .clk     (clk),
                .rst     (rst),
                .en      (div_en),
                .clk_out (grp_clk[g])
            );
        end
    endgenerate

    assign pin_oe = straps_valid && !cfg.hiz;

    // enable changes only in the low phase so the gated reference never glitches
    always_ff @(negedge clk) begin
        if (rst) ref_gate <= 1'b0;
        else     ref_gate <= pin_oe;
    end

    assign pin_out = clk & ref_gate;
endmodule

// File: rtl/strap_mode_chk.sv
`timescale 1ns/1ps
module strap_mode_chk (
    input logic       clk,
    input logic       rst,
    input logic       straps_valid,
    input logic [2:0] straps_o,
    input logic       pin_oe,
    input logic       outs_hiz,
    input logic       test_mode,
    input logic [5:0] grp_clk
);
    assert_capture_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        straps_valid |=> straps_valid);

    assert_straps_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        straps_valid |=> $stable(straps_o));

    assert_pin_undriven_R3: assert property (@(posedge clk) disable iff (rst)
        !straps_valid |-> !pin_oe);

    assert_float_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        outs_hiz |-> (grp_clk == 6'd0 && !pin_oe));

    assert_mode_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({outs_hiz, test_mode}));

    assert_groups_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> grp_clk == 6'd0);
endmodule

bind strap_mode_ctrl strap_mode_chk u_chk (.*);

// File: tb/strap_mode_ctrl_bench.sv
`timescale 1ns/1ps
module strap_mode_ctrl_bench;
    localparam int DLY = 16;
    localparam int WIN = 48;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_pin_in = 1'b0;
    logic [1:0] sel_lo = 2'b11;
    logic       straps_valid;
    logic [2:0] straps_o;
    logic       pin_oe, pin_out, outs_hiz, test_mode;
    logic [1:0] cpu_freq;
    logic       sdram_freq, inv_cpu, inv_sdram, inv_mid;
    logic [5:0] grp_clk;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    strap_mode_ctrl #(.CAPTURE_DLY(DLY)) u_strap_mode_ctrl (
        .clk(clk), .rst(rst), .strap_pin_in(strap_pin_in), .sel_lo(sel_lo),
        .straps_valid(straps_valid), .straps_o(straps_o), .pin_oe(pin_oe),
        .pin_out(pin_out), .outs_hiz(outs_hiz), .test_mode(test_mode),
        .cpu_freq(cpu_freq), .sdram_freq(sdram_freq), .inv_cpu(inv_cpu),
        .inv_sdram(inv_sdram), .inv_mid(inv_mid), .grp_clk(grp_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put_straps(input logic [2:0] c);
        strap_pin_in = c[2];
        sel_lo       = c[1:0];
    endtask

    task automatic expect_for(input logic [2:0] c, output int hz, output int ts,
                              output int cf, output int sd, output int ic,
                              output int isd, output int im);
        hz = 0; ts = 0; cf = 3; sd = 0; ic = 0; isd = 0; im = 0;
        if (c[1:0] == 2'b00)      hz = 1;
        else if (c[1:0] == 2'b01) ts = 1;
        else if (c == 3'b010) begin cf = 0; ic = 1; im = 1; end
        else if (c == 3'b011) begin cf = 1; ic = 1; isd = 1; end
        else if (c == 3'b110) begin cf = 2; sd = 1; end
        else                  begin cf = 2; ic = 1; isd = 1; end
    endtask

    function automatic int div_of(input int g);
        if (g == 2) return 3;
        if (g == 3 || g == 4) return 6;
        return 2;
    endfunction

    task automatic release_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic run_code(input logic [2:0] code);
        int hz, ts, cf, sd, ic, isd, im;
        int highs [6];
        int rises [6];
        logic [5:0] prev;
        int pin_bad;
        expect_for(code, hz, ts, cf, sd, ic, isd, im);
        put_straps(code);
        release_reset();
        repeat (DLY - 1) @(posedge clk);
        #1;
        check(straps_valid == 1'b0, "R1 valid before capture", int'(straps_valid), 0);
        check(pin_oe == 1'b0, "R3 pin undriven before capture", int'(pin_oe), 0);
        check(straps_o == 3'b011, "R10 open default before capture", int'(straps_o), 3);
        check(grp_clk == 6'd0, "R9 groups low before capture", int'(grp_clk), 0);
        @(posedge clk);
        #1;
        check(straps_valid == 1'b1, "R1 valid at capture edge", int'(straps_valid), 1);
        check(straps_o == code, "R1 captured code", int'(straps_o), int'(code));
        put_straps(~code);
        repeat (5) @(posedge clk);
        #1;
        check(straps_o == code, "R2 later strap change ignored", int'(straps_o), int'(code));
        check(int'(outs_hiz) == hz, "R5 float flag", int'(outs_hiz), hz);
        check(int'(test_mode) == ts, "R6 test flag", int'(test_mode), ts);
        check(int'(cpu_freq) == cf, "R7 cpu code", int'(cpu_freq), cf);
        check(int'(sdram_freq) == sd, "R7 sdram code", int'(sdram_freq), sd);
        check(int'(inv_cpu) == ic, "R8 cpu inversion", int'(inv_cpu), ic);
        check(int'(inv_sdram) == isd, "R8 sdram inversion", int'(inv_sdram), isd);
        check(int'(inv_mid) == im, "R8 mid inversion", int'(inv_mid), im);
        check(int'(pin_oe) == 1 - hz, "R3 pin drive after capture", int'(pin_oe), 1 - hz);
        for (int g = 0; g < 6; g++) begin highs[g] = 0; rises[g] = 0; end
        pin_bad = 0;
        prev = 6'd0;
        for (int k = 0; k < 2 * WIN; k++) begin
            if (k % 2 == 0) @(posedge clk);
            else            @(negedge clk);
            #1;
            if (k % 2 == 0) begin
                if (pin_out !== (1 - hz)) pin_bad++;
            end else begin
                if (pin_out !== 1'b0) pin_bad++;
            end
            for (int g = 0; g < 6; g++) begin
                if (grp_clk[g]) highs[g]++;
                if (k > 0 && grp_clk[g] && !prev[g]) rises[g]++;
            end
            prev = grp_clk;
        end
        check(pin_bad == 0, "R4 shared pin waveform", pin_bad, 0);
        for (int g = 0; g < 6; g++) begin
            if (ts == 1) begin
                check(highs[g] == WIN, "R6 group duty", highs[g], WIN);
                check(rises[g] == WIN / div_of(g) || rises[g] == WIN / div_of(g) - 1,
                      "R6 group edge count", rises[g], WIN / div_of(g));
            end else begin
                check(highs[g] == 0, hz == 1 ? "R5 group held low" : "R9 group held low",
                      highs[g], 0);
            end
        end
    endtask

    task automatic same_cycle_capture();
        logic [2:0] first_code;
        logic [2:0] late_code;
        first_code = 3'b110;
        late_code  = 3'b001;
        put_straps(late_code);
        release_reset();
        repeat (DLY - 1) @(posedge clk);
        #1 put_straps(first_code);
        @(posedge clk);
        #1 put_straps(late_code);
        check(straps_o == first_code, "R1 value before capture edge wins",
              int'(straps_o), int'(first_code));
        check(pin_oe == 1'b1, "R3 drive enable on capture edge", int'(pin_oe), 1);
        repeat (4) @(posedge clk);
        #1;
        check(straps_o == first_code, "R2 value after capture edge ignored",
              int'(straps_o), int'(first_code));
        check(cpu_freq == 2'd2 && sdram_freq == 1'b1 && !test_mode,
              "R7 decode follows captured value", int'(cpu_freq), 2);
    endtask

    initial begin
        #1;
        check(straps_valid == 1'b0, "R1 reset state", int'(straps_valid), 0);
        @(posedge clk);
        #1;
        check(pin_oe == 1'b0 && straps_o == 3'b011, "R10 reset state", int'(straps_o), 3);
        for (int c = 0; c < 8; c++) run_code(3'(c));
        same_cycle_capture();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule